// File: doc/BRIEF.md
# Processor-Side Bus Handoff Arbiter

This controller decides who owns a shared multiplexed address/data bus and its command bus. In master state the processor drives both buses. In slave state an external agent drives them. An agent asks for the bus by pulling an active-low request line low. When the core signals that it can give the bus up, the controller emits a one-cycle active-low release pulse and turns both of its drive enables off. The agent may then drive the buses, but only from the second cycle after the pulse onward.

The interface stays in slave state across a string of external requests for as long as the request line is held low. When the agent signals that it is done and the request line is high, ownership returns to the processor, which drives again in the following cycle. After a processor read, the core can also move the interface to slave state by itself, through an uncompelled-release strobe. In that case no pulse is issued and the agent may start at once.

A flag reports any cycle in which the agent drives while the processor drives, or while the two-cycle turnaround is still running. All outputs come straight from registers.

Top module: `bus_handoff_arbiter`

## Requirements
- R1: While reset is high and in the cycle after it, release_n is 1, both drive enables are 0, slave_mode is 0 and bus_clash is 0.
- R2: In master state, if ext_req_n is 0 and core_ready is 1 at a clock edge, then after that edge release_n is 0, slave_mode is 1 and both drive enables are 0.
- R3: release_n is low for exactly one cycle. The interface is then in slave state with release_n high, and no second pulse follows while the agent holds the bus.
- R4: In master state, while core_ready is 0 and uncompelled_rel is 0, an external request leaves the interface in master state with the drive enables on.
- R5: Both drive enables are 0 in every cycle in which slave_mode is 1, including the release cycle.
- R6: If agent_drive is 1 in the release cycle or in the cycle after it, bus_clash is 1 in the next cycle. Agent driving from the second cycle after the release cycle onward does not set bus_clash.
- R7: In slave state after the release cycle, agent_done=1 with ext_req_n=1 at an edge returns the interface to master state. slave_mode goes to 0 and both drive enables go to 1 after that edge.
- R8: In slave state, agent_done=1 while ext_req_n is 0 keeps the interface in slave state (a chained request), with no new release pulse.
- R9: In master state, uncompelled_rel=1 at an edge moves the interface to slave state with no release pulse and no turnaround window. It takes priority over a pending external request.
- R10: If agent_drive is 1 while the processor's drive enables are on, bus_clash is 1 in the next cycle. Otherwise it is 0.
- R11: agent_done has no effect in master state or in the release cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_n | input | 1 | Active-low external bus request |
| core_ready | input | 1 | Core is ready to release the bus for an external request |
| uncompelled_rel | input | 1 | Core enters slave state on its own (after a read request) |
| agent_done | input | 1 | Agent has finished its request and tri-stated the buses |
| agent_drive | input | 1 | Agent is driving the buses this cycle |
| release_n | output | 1 | Active-low one-cycle release pulse |
| ad_drive_en | output | 1 | Processor drive enable, address/data bus |
| cmd_drive_en | output | 1 | Processor drive enable, command bus |
| slave_mode | output | 1 | 1 while the interface is in slave state (including the release cycle) |
| bus_clash | output | 1 | Drive conflict or early agent drive seen in the previous cycle |

## Verification
The assertions assume that agent_done only matters once the release cycle has passed. They also assume the agent follows the agreed protocol, so the clash flag rises only where a test creates a fault on purpose. The stimulus changes inputs just after a clock edge and holds them through the next edge. It raises agent_drive only in windows where a test expects a specific flag value. It clears agent_done and uncompelled_rel after a single edge, so each handoff is decided by one clean input pattern.

// File: rtl/bus_handoff_pkg.sv
package bus_handoff_pkg;

    typedef enum logic [1:0] {
        OWN_MASTER  = 2'd0,
        OWN_RELEASE = 2'd1,
        OWN_SLAVE   = 2'd2
    } own_state_e;

    localparam int unsigned NUM_DRIVERS = 2;
    localparam int unsigned DRV_AD      = 0;
    localparam int unsigned DRV_CMD     = 1;

    function automatic logic core_owns(input own_state_e s);
        return (s == OWN_MASTER);
    endfunction

    function automatic logic in_release(input own_state_e s);
        return (s == OWN_RELEASE);
    endfunction

endpackage

// File: rtl/handoff_fsm.sv
module handoff_fsm
    import bus_handoff_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ext_req_n,
    input  logic       core_ready,
    input  logic       uncompelled_rel,
    input  logic       agent_done,
    output own_state_e state_q,
    output own_state_e state_d
);

    always_comb begin
        state_d = state_q;
        case (state_q)
            OWN_MASTER: begin
                // a self-initiated handoff wins over an external request
                if (uncompelled_rel)
                    state_d = OWN_SLAVE;
                else if (!ext_req_n && core_ready)
                    state_d = OWN_RELEASE;
            end
            OWN_RELEASE: state_d = OWN_SLAVE;
            OWN_SLAVE: begin
                // a held request line chains the next external request
                if (agent_done && ext_req_n)
                    state_d = OWN_MASTER;
            end
            default: state_d = OWN_MASTER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= OWN_MASTER;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/handoff_drive.sv
module handoff_drive
    import bus_handoff_pkg::*;
#(
    parameter int unsigned N_DRV = NUM_DRIVERS
) (
    input  logic             clk,
    input  logic             rst,
    input  own_state_e       state_d,
    output logic [N_DRV-1:0] drv_en,
    output logic             release_n,
    output logic             slave_mode
);

    for (genvar g = 0; g < N_DRV; g++) begin : g_drv
        logic en_q;
        always_ff @(posedge clk) begin
            if (rst) en_q <= 1'b0;
            else     en_q <= core_owns(state_d);
        end
        assign drv_en[g] = en_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            release_n  <= 1'b1;
            slave_mode <= 1'b0;
        end else begin
            release_n  <= !in_release(state_d);
            slave_mode <= !core_owns(state_d);
        end
    end

endmodule

// File: rtl/handoff_guard.sv
module handoff_guard #(
    parameter int unsigned TURN_CYC = 2,
    localparam int unsigned CNT_W   = $clog2(TURN_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic proc_drv,
    input  logic agent_drive,
    output logic bus_clash
);

    logic [CNT_W-1:0] turn_cnt;
    logic             turn_busy;

    assign turn_busy = (turn_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst)
            turn_cnt <= '0;
        else if (start)
            turn_cnt <= CNT_W'(TURN_CYC);
        else if (turn_busy)
            turn_cnt <= turn_cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) bus_clash <= 1'b0;
        else     bus_clash <= agent_drive && (proc_drv || turn_busy);
    end

endmodule

// File: rtl/bus_handoff_arbiter.sv
module bus_handoff_arbiter
    import bus_handoff_pkg::*;
#(
    parameter int unsigned TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_req_n,
    input  logic core_ready,
    input  logic uncompelled_rel,
    input  logic agent_done,
    input  logic agent_drive,
    output logic release_n,
    output logic ad_drive_en,
    output logic cmd_drive_en,
    output logic slave_mode,
    output logic bus_clash
);

    own_state_e             state_q;
    own_state_e             state_d;
    logic [NUM_DRIVERS-1:0] drv_en;

    handoff_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .ext_req_n       (ext_req_n),
        .core_ready      (core_ready),
        .uncompelled_rel (uncompelled_rel),
        .agent_done      (agent_done),
        .state_q         (state_q),
        .state_d         (state_d)
    );

    handoff_drive #(.N_DRV(NUM_DRIVERS)) u_drive (
        .clk        (clk),
        .rst        (rst),
        .state_d    (state_d),
        .drv_en     (drv_en),
        .release_n  (release_n),
        .slave_mode (slave_mode)
    );

    handoff_guard #(.TURN_CYC(TURN_CYC)) u_guard (
        .clk         (clk),
        .rst         (rst),
        .start       (in_release(state_d)),
        .proc_drv    (|drv_en),
        .agent_drive (agent_drive),
        .bus_clash   (bus_clash)
    );

    assign ad_drive_en  = drv_en[DRV_AD];
    assign cmd_drive_en = drv_en[DRV_CMD];

endmodule

// File: rtl/bus_handoff_checker.sv
module bus_handoff_checker (
    input logic clk,
    input logic rst,
    input logic ext_req_n,
    input logic core_ready,
    input logic uncompelled_rel,
    input logic agent_done,
    input logic agent_drive,
    input logic release_n,
    input logic ad_drive_en,
    input logic cmd_drive_en,
    input logic slave_mode,
    input logic bus_clash
);

    assert_req_release_R2: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !uncompelled_rel && !ext_req_n && core_ready)
        |=> (!release_n && slave_mode));

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        !release_n |=> (release_n && slave_mode));

    assert_hold_unready_R4: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && !core_ready && !uncompelled_rel) |=> !slave_mode);

    assert_off_in_slave_R5: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> (!ad_drive_en && !cmd_drive_en));

    assert_early_drive_R6: assert property (@(posedge clk) disable iff (rst)
        (!release_n && agent_drive) |=> bus_clash);

    assert_return_R7: assert property (@(posedge clk) disable iff (rst)
        (slave_mode && release_n && agent_done && ext_req_n)
        |=> (!slave_mode && ad_drive_en && cmd_drive_en));

    assert_chain_R8: assert property (@(posedge clk) disable iff (rst)
        (slave_mode && release_n && !ext_req_n) |=> (slave_mode && release_n));

    assert_uncompelled_R9: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode && uncompelled_rel) |=> (slave_mode && release_n));

    assert_clash_R10: assert property (@(posedge clk) disable iff (rst)
        (ad_drive_en && agent_drive) |=> bus_clash);

endmodule

bind bus_handoff_arbiter bus_handoff_checker u_chk (
    .clk             (clk),
    .rst             (rst),
    .ext_req_n       (ext_req_n),
    .core_ready      (core_ready),
    .uncompelled_rel (uncompelled_rel),
    .agent_done      (agent_done),
    .agent_drive     (agent_drive),
    .release_n       (release_n),
    .ad_drive_en     (ad_drive_en),
    .cmd_drive_en    (cmd_drive_en),
    .slave_mode      (slave_mode),
    .bus_clash       (bus_clash)
);

// File: tb/tb_bus_handoff_arbiter.sv
`timescale 1ns/1ps
module tb_bus_handoff_arbiter;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_req_n = 1'b1;
    logic core_ready = 1'b0;
    logic uncompelled_rel = 1'b0;
    logic agent_done = 1'b0;
    logic agent_drive = 1'b0;
    logic release_n, ad_drive_en, cmd_drive_en, slave_mode, bus_clash;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    bus_handoff_arbiter dut (
        .clk(clk), .rst(rst), .ext_req_n(ext_req_n), .core_ready(core_ready),
        .uncompelled_rel(uncompelled_rel), .agent_done(agent_done),
        .agent_drive(agent_drive), .release_n(release_n),
        .ad_drive_en(ad_drive_en), .cmd_drive_en(cmd_drive_en),
        .slave_mode(slave_mode), .bus_clash(bus_clash)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_master(input string req);
        chk(req, "slave_mode", slave_mode, 1'b0);
        chk(req, "ad_drive_en", ad_drive_en, 1'b1);
        chk(req, "cmd_drive_en", cmd_drive_en, 1'b1);
        chk(req, "release_n", release_n, 1'b1);
    endtask

    task automatic chk_slave_off(input string req, input logic rel_exp);
        chk(req, "slave_mode", slave_mode, 1'b1);
        chk(req, "ad_drive_en", ad_drive_en, 1'b0);
        chk(req, "cmd_drive_en", cmd_drive_en, 1'b0);
        chk(req, "release_n", release_n, rel_exp);
    endtask

    // bring the bus back to the processor from plain slave state
    task automatic give_back();
        ext_req_n = 1'b1; agent_done = 1'b1; agent_drive = 1'b0;
        step();
        agent_done = 1'b0;
        chk_master("R7");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        chk("R1", "release_n", release_n, 1'b1);
        chk("R1", "ad_drive_en", ad_drive_en, 1'b0);
        chk("R1", "cmd_drive_en", cmd_drive_en, 1'b0);
        chk("R1", "slave_mode", slave_mode, 1'b0);
        chk("R1", "bus_clash", bus_clash, 1'b0);
        rst = 1'b0;
        step();
        chk_master("R1");
    endtask

    task automatic t_handoff();
        ext_req_n = 1'b0; core_ready = 1'b1;
        step();
        core_ready = 1'b0;
        chk_slave_off("R2", 1'b0);
        step();
        chk_slave_off("R3", 1'b1);
        step();
        agent_drive = 1'b1;          // second cycle after release: allowed
        step();
        agent_drive = 1'b0;
        chk("R6", "bus_clash late drive", bus_clash, 1'b0);
        chk_slave_off("R5", 1'b1);
        step();
        chk("R3", "no second pulse", release_n, 1'b1);
        give_back();
        chk("R6", "bus_clash after return", bus_clash, 1'b0);
    endtask

    task automatic t_not_ready();
        ext_req_n = 1'b0; core_ready = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            chk_master("R4");
        end
        ext_req_n = 1'b1;
    endtask

    task automatic t_early_drive();
        ext_req_n = 1'b0; core_ready = 1'b1;
        step();
        core_ready = 1'b0;
        agent_drive = 1'b1;          // in the release cycle
        step();
        agent_drive = 1'b0;
        chk("R6", "bus_clash release cycle", bus_clash, 1'b1);
        agent_drive = 1'b1;          // cycle after release
        step();
        agent_drive = 1'b0;
        chk("R6", "bus_clash turnaround", bus_clash, 1'b1);
        step();
        chk("R6", "bus_clash cleared", bus_clash, 1'b0);
        give_back();
    endtask

    task automatic t_chain();
        ext_req_n = 1'b0; core_ready = 1'b1;
        step();
        core_ready = 1'b0;
        step();
        step();
        agent_done = 1'b1;           // first request ends, line still low
        step();
        agent_done = 1'b0;
        chk_slave_off("R8", 1'b1);
        step();
        chk_slave_off("R8", 1'b1);
        agent_done = 1'b1;           // second request ends, line still low
        step();
        agent_done = 1'b0;
        chk_slave_off("R8", 1'b1);
        give_back();
    endtask

    task automatic t_uncompelled();
        uncompelled_rel = 1'b1; ext_req_n = 1'b0; core_ready = 1'b1;
        step();
        uncompelled_rel = 1'b0; core_ready = 1'b0;
        chk_slave_off("R9", 1'b1);
        agent_drive = 1'b1;          // may drive at once
        step();
        agent_drive = 1'b0;
        chk("R9", "bus_clash no turnaround", bus_clash, 1'b0);
        chk("R9", "release_n", release_n, 1'b1);
        give_back();
    endtask

    task automatic t_clash();
        agent_drive = 1'b1;
        step();
        agent_drive = 1'b0;
        chk("R10", "bus_clash set", bus_clash, 1'b1);
        step();
        chk("R10", "bus_clash clear", bus_clash, 1'b0);
    endtask

    task automatic t_done_ignored();
        agent_done = 1'b1; ext_req_n = 1'b1;
        step();
        agent_done = 1'b0;
        chk_master("R11");
        ext_req_n = 1'b0; core_ready = 1'b1;
        step();
        core_ready = 1'b0;
        ext_req_n = 1'b1; agent_done = 1'b1;   // done during release cycle
        step();
        agent_done = 1'b0;
        chk_slave_off("R11", 1'b1);
        give_back();
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_handoff();
        t_not_ready();
        t_early_drive();
        t_chain();
        t_uncompelled();
        t_clash();
        t_done_ignored();
        step();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule